// File: doc/BRIEF.md
# Bipolar Line Code Decoder with Violation Strobe

This block sits behind a line receiver's slicer and clock recovery. Each recovered bit arrives as a pair of rail pulses. A pulse on the positive rail is a positive mark, a pulse on the negative rail is a negative mark, and no pulse is a space. A bit-valid strobe marks the clock cycles that carry a bit. The block turns the pulse stream back into unipolar data. It also raises a one-bit-period strobe for every bipolar violation that the selected line code cannot explain.

Three line codes are decoded:

- **Plain alternate mark inversion.** Every mark is a one, and marks are expected to alternate in polarity.
- **Eight-zero substitution.** Runs of eight zeros were replaced by a codeword that carries two intentional violations.
- **High-density four-zero substitution.** Runs of four zeros were replaced by `000V` or `B00V`.

The code is picked by a substitution enable together with the 3-bit line-length select. This lets the receive code be configured separately from any transmit code.

Decoded bits leave through an eight-stage window, so that a whole codeword can be recognised and rewritten before its first bit is released. The data output and the strobe output are therefore registered together, with a fixed latency of eight accepted bits.

Top module: `bpdec_top`

## Requirements
- R1: While reset is high, and in the cycle after reset is applied, `dataOut` and `bpvOut` are low.
- R2: The decoded value of the n-th accepted bit (counting from 0 after reset) appears on the outputs right after the clock edge of the (n+8)-th accepted bit. The outputs for the first eight accepted bits after reset are low.
- R3: The outputs change only on clock edges where `bitValid` is high. Between accepted bits they hold their value, so each strobe lasts one bit period.
- R4: Code selection works as follows:
  - With `codeSel` low, plain alternate mark inversion is decoded for every `lenSel`.
  - With `codeSel` high, `lenSel` = 3'b000 selects four-zero substitution.
  - With `codeSel` high, `lenSel` from 3'b010 to 3'b111 selects eight-zero substitution.
  - With `codeSel` high, `lenSel` = 3'b001 falls back to plain decoding, and codewords pass through as marks with their violations flagged.
- R5: A single-rail mark (posRail high = positive, negRail high = negative) decodes as a one. It raises the strobe when a single-rail mark has been seen since reset and the most recent one had the same polarity. The first mark after reset never raises the strobe.
- R6: A bit with both rails high decodes as a one with the strobe raised, in every code. It does not change the remembered polarity of the last mark.
- R7: In eight-zero substitution mode, take P as the polarity of the preceding mark. The pattern space, space, space, P, −P, space, −P, P decodes as eight zeros with no strobe.
- R8: In four-zero substitution mode, both patterns decode as four zeros with no strobe:
  - three spaces followed by a mark of the same polarity as the preceding mark;
  - a properly alternating mark, two spaces, then a mark of that same polarity.
- R9: `bpvOut` is never high while `dataOut` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bitValid | input | 1 | High in cycles that carry a received bit |
| posRail | input | 1 | Positive-rail pulse for this bit |
| negRail | input | 1 | Negative-rail pulse for this bit |
| codeSel | input | 1 | Substitution decoding enable |
| lenSel | input | 3 | Line-length select; picks the substitution code |
| dataOut | output | 1 | Recovered unipolar data |
| bpvOut | output | 1 | Bipolar violation strobe, aligned with dataOut |

## Verification
The assertions watch four things on every cycle:

- the reset values of the outputs;
- that the outputs hold between accepted bits;
- that the strobe never appears without a one;
- that the outputs stay silent during the first eight accepted bits.

They also check that codeword removal is only ever triggered with substitution enabled, and only for the matching `lenSel` range.

Whether removal happens at the right places, restoring the original data, can only be shown by the bench's scenarios. The same holds for whether violation strobes land on exactly the right bits. The bench encodes random data with its own encoders and compares the decoded stream against the original. It also runs random rail patterns, including double-rail pulses, against an alternation model.

// File: rtl/bpdec_pkg.sv
package bpdec_pkg;

  // One received bit after classification at the input
  typedef struct packed {
    logic one;    // bit decodes as a one
    logic vio;    // bipolar violation against the previous mark
    logic pos;    // polarity of a single-rail mark (1 = positive)
    logic clean;  // exactly one rail was high
  } sym_t;

  typedef enum logic [1:0] {
    MODE_AMI  = 2'd0,
    MODE_B8   = 2'd1,
    MODE_HDB  = 2'd2
  } mode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftEn;  // accept the incoming bit
    sym_t inSym;    // classified incoming bit
    logic clrB8;    // rewrite the newest eight stages as zeros
    logic clrHdb;   // rewrite the newest four stages as zeros
  } ctrl_t;

  localparam int CW_B8  = 8;
  localparam int CW_HDB = 4;

endpackage

// File: rtl/bpdec_control.sv
module bpdec_control
  import bpdec_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int LEN_W   = 3,
  parameter int HDB_SEL = 0,
  parameter int B8_MIN  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bitValid,
  input  logic                  posRail,
  input  logic                  negRail,
  input  logic                  codeSel,
  input  logic [LEN_W-1:0]      lenSel,
  input  sym_t [DEPTH-1:0]      win,
  output ctrl_t                 ctrl
);

  localparam logic [LEN_W-1:0] HDB_CODE = LEN_W'(HDB_SEL);
  localparam logic [LEN_W-1:0] B8_LOW   = LEN_W'(B8_MIN);

  mode_e mode;
  logic  haveMark;
  logic  lastPol;
  sym_t  newSym;
  logic  b8Hit;
  logic  hdbHit;

  // Code selection from the enable and the length select
  always_comb begin
    mode = MODE_AMI;
    if (codeSel) begin
      if (lenSel == HDB_CODE)    mode = MODE_HDB;
      else if (lenSel >= B8_LOW) mode = MODE_B8;
    end
  end

  // Classify the incoming bit against the remembered polarity
  always_comb begin
    newSym.clean = posRail ^ negRail;
    newSym.one   = posRail | negRail;
    newSym.pos   = posRail;
    newSym.vio   = (posRail & negRail) |
                   (newSym.clean & haveMark & (posRail == lastPol));
  end

  // Polarity memory follows single-rail marks only
  always_ff @(posedge clk) begin
    if (rst) begin
      haveMark <= 1'b0;
      lastPol  <= 1'b0;
    end else if (bitValid && newSym.clean) begin
      haveMark <= 1'b1;
      lastPol  <= posRail;
    end
  end

  // Eight-zero codeword ending at the incoming bit:
  // win[6..4] space, win[3] V, win[2] B, win[1] space, win[0] V, new B
  always_comb begin
    b8Hit = (mode == MODE_B8) &&
            !win[6].one && !win[5].one && !win[4].one &&
            win[3].clean && win[3].vio &&
            win[2].clean && !win[2].vio && (win[2].pos != win[3].pos) &&
            !win[1].one &&
            win[0].clean && win[0].vio && (win[0].pos == win[2].pos) &&
            newSym.clean && !newSym.vio && (newSym.pos != win[0].pos);
  end

  // Four-zero codeword ending at the incoming bit: 000V or B00V
  always_comb begin
    hdbHit = (mode == MODE_HDB) &&
             !win[0].one && !win[1].one &&
             newSym.clean && newSym.vio &&
             (!win[2].one || (win[2].clean && !win[2].vio));
  end

  always_comb begin
    ctrl.shiftEn = bitValid;
    ctrl.inSym   = newSym;
    ctrl.clrB8   = bitValid & b8Hit;
    ctrl.clrHdb  = bitValid & hdbHit;
  end

endmodule

// File: rtl/bpdec_datapath.sv
module bpdec_datapath
  import bpdec_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl,
  output sym_t [DEPTH-1:0] win,
  output logic             dataOut,
  output logic             bpvOut
);

  sym_t [DEPTH-1:0] stg;
  logic [DEPTH-1:0] clrVec;

  // Stage g is cleared when it lands inside a recognised codeword
  always_comb begin
    for (int g = 0; g < DEPTH; g++) begin
      clrVec[g] = (ctrl.clrB8 && (g < CW_B8)) || (ctrl.clrHdb && (g < CW_HDB));
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gStage
    sym_t src;
    if (g == 0) begin : gHead
      assign src = ctrl.inSym;
    end else begin : gBody
      assign src = stg[g-1];
    end

    always_ff @(posedge clk) begin
      if (rst)               stg[g] <= '0;
      else if (ctrl.shiftEn) stg[g] <= clrVec[g] ? sym_t'('0) : src;
    end
  end

  // Oldest stage leaves through the output registers
  always_ff @(posedge clk) begin
    if (rst) begin
      dataOut <= 1'b0;
      bpvOut  <= 1'b0;
    end else if (ctrl.shiftEn) begin
      dataOut <= stg[DEPTH-1].one;
      bpvOut  <= stg[DEPTH-1].vio;
    end
  end

  assign win = stg;

endmodule

// File: rtl/bpdec_top.sv
module bpdec_top
  import bpdec_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int LEN_W   = 3,
  parameter int HDB_SEL = 0,
  parameter int B8_MIN  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bitValid,
  input  logic             posRail,
  input  logic             negRail,
  input  logic             codeSel,
  input  logic [LEN_W-1:0] lenSel,
  output logic             dataOut,
  output logic             bpvOut
);

  ctrl_t            ctrl;
  sym_t [DEPTH-1:0] win;

  bpdec_control #(
    .DEPTH(DEPTH), .LEN_W(LEN_W), .HDB_SEL(HDB_SEL), .B8_MIN(B8_MIN)
  ) ctrl_i (
    .clk(clk), .rst(rst), .bitValid(bitValid),
    .posRail(posRail), .negRail(negRail),
    .codeSel(codeSel), .lenSel(lenSel),
    .win(win), .ctrl(ctrl)
  );

  bpdec_datapath #(.DEPTH(DEPTH)) dp_i (
    .clk(clk), .rst(rst), .ctrl(ctrl),
    .win(win), .dataOut(dataOut), .bpvOut(bpvOut)
  );

endmodule

// File: rtl/bpdec_checker.sv
module bpdec_checker
  import bpdec_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int LEN_W   = 3,
  parameter int HDB_SEL = 0,
  parameter int B8_MIN  = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             bitValid,
  input logic             codeSel,
  input logic [LEN_W-1:0] lenSel,
  input logic             dataOut,
  input logic             bpvOut,
  input ctrl_t            ctrl
);

  localparam int CW = $clog2(DEPTH + 1);
  logic [CW-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst)                                  seen <= '0;
    else if (bitValid && (seen != CW'(DEPTH))) seen <= seen + 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!dataOut && !bpvOut));

  // R2
  warmup_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (bitValid && (seen < CW'(DEPTH))) |=> (!dataOut && !bpvOut));

  // R3
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    !bitValid |=> ($stable(dataOut) && $stable(bpvOut)));

  // R9
  strobe_with_one_chk: assert property (@(posedge clk) disable iff (rst)
    bpvOut |-> dataOut);

  // R4
  sub_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.clrB8 || ctrl.clrHdb) |-> (codeSel && bitValid));

  // R4
  b8_range_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.clrB8 |-> (lenSel >= LEN_W'(B8_MIN)));

  // R4
  hdb_range_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.clrHdb |-> (lenSel == LEN_W'(HDB_SEL)));

endmodule

bind bpdec_top bpdec_checker #(
  .DEPTH(DEPTH), .LEN_W(LEN_W), .HDB_SEL(HDB_SEL), .B8_MIN(B8_MIN)
) chk_i (
  .clk(clk), .rst(rst), .bitValid(bitValid), .codeSel(codeSel),
  .lenSel(lenSel), .dataOut(dataOut), .bpvOut(bpvOut), .ctrl(ctrl)
);

// File: tb/bpdec_top_tb_top.sv
module bpdec_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int MAXN       = 400;
  localparam int RUNLEN     = 260;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bitValid = 1'b0;
  logic       posRail = 1'b0;
  logic       negRail = 1'b0;
  logic       codeSel = 1'b0;
  logic [2:0] lenSel = 3'd0;
  logic       dataOut;
  logic       bpvOut;

  int   nChecks = 0;
  int   nFails  = 0;
  logic done    = 1'b0;

  logic [1:0] symArr [MAXN];
  logic       datArr [MAXN];
  logic       expD   [MAXN];
  logic       expV   [MAXN];
  int         total;

  bpdec_top dut_i (
    .clk(clk), .rst(rst), .bitValid(bitValid), .posRail(posRail),
    .negRail(negRail), .codeSel(codeSel), .lenSel(lenSel),
    .dataOut(dataOut), .bpvOut(bpvOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic ok, input string tag,
                       input logic [1:0] act, input logic [1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: {data,bpv} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic v, input logic p, input logic n);
    @(negedge clk);
    bitValid = v;
    posRail  = p;
    negRail  = n;
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    bitValid = 1'b0;
    @(posedge clk);
    #1;
    check(!dataOut && !bpvOut, "R1", {dataOut, bpvOut}, 2'b00);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Data with long zero runs; the tail is DEPTH zeros for flushing
  task automatic genData();
    int i = 0;
    total = RUNLEN;
    while (i < total) begin
      if (i < 2 || i >= total - DEPTH) begin
        datArr[i] = (i < 2);
        i++;
      end else if ($urandom % 4 == 0) begin
        int len = 4 + int'($urandom % 11);
        for (int j = 0; j < len && i < total - DEPTH; j++) begin
          datArr[i] = 1'b0;
          i++;
        end
      end else begin
        datArr[i] = 1'b1;
        i++;
        if (i < total - DEPTH) begin
          datArr[i] = 1'($urandom);
          i++;
        end
      end
    end
  endtask

  function automatic logic [1:0] markOf(input logic pol);
    return pol ? 2'b10 : 2'b01;
  endfunction

  task automatic encB8();
    logic lastP = 1'b0;
    int i = 0;
    while (i < total) begin
      logic run8 = (i + 8 <= total);
      for (int j = 0; j < 8 && run8; j++) if (datArr[i+j]) run8 = 1'b0;
      if (run8) begin
        symArr[i]   = 2'b00;
        symArr[i+1] = 2'b00;
        symArr[i+2] = 2'b00;
        symArr[i+3] = markOf(lastP);
        symArr[i+4] = markOf(!lastP);
        symArr[i+5] = 2'b00;
        symArr[i+6] = markOf(!lastP);
        symArr[i+7] = markOf(lastP);
        i += 8;
      end else begin
        if (datArr[i]) begin
          lastP = !lastP;
          symArr[i] = markOf(lastP);
        end else begin
          symArr[i] = 2'b00;
        end
        i++;
      end
    end
  endtask

  task automatic encHdb();
    logic lastP = 1'b0;
    int   cnt   = 0;
    int   i     = 0;
    while (i < total) begin
      logic run4 = (i + 4 <= total);
      for (int j = 0; j < 4 && run4; j++) if (datArr[i+j]) run4 = 1'b0;
      if (run4) begin
        symArr[i+1] = 2'b00;
        symArr[i+2] = 2'b00;
        if (cnt % 2 == 1) begin
          symArr[i] = 2'b00;
        end else begin
          lastP = !lastP;
          symArr[i] = markOf(lastP);
        end
        symArr[i+3] = markOf(lastP);
        cnt = 0;
        i += 4;
      end else begin
        if (datArr[i]) begin
          lastP = !lastP;
          symArr[i] = markOf(lastP);
          cnt++;
        end else begin
          symArr[i] = 2'b00;
        end
        i++;
      end
    end
  endtask

  task automatic genRandSym();
    total = RUNLEN;
    for (int i = 0; i < total; i++) symArr[i] = 2'($urandom);
  endtask

  // Plain alternation rule (R5, R6)
  task automatic amiModel();
    logic haveM = 1'b0;
    logic lastP = 1'b0;
    for (int i = 0; i < total; i++) begin
      case (symArr[i])
        2'b11: begin expD[i] = 1'b1; expV[i] = 1'b1; end
        2'b10, 2'b01: begin
          expD[i] = 1'b1;
          expV[i] = haveM && (symArr[i][1] == lastP);
          haveM = 1'b1;
          lastP = symArr[i][1];
        end
        default: begin expD[i] = 1'b0; expV[i] = 1'b0; end
      endcase
    end
  endtask

  task automatic dataModel();
    for (int i = 0; i < total; i++) begin
      expD[i] = datArr[i];
      expV[i] = 1'b0;
    end
  endtask

  task automatic runStream(input string tag, input logic cs, input logic [2:0] ls);
    logic [1:0] held;
    codeSel = cs;
    lenSel  = ls;
    doReset();
    held = 2'b00;
    for (int k = 0; k < total; k++) begin
      if ($urandom % 3 == 0) begin
        step(1'b0, 1'($urandom), 1'($urandom));
        check({dataOut, bpvOut} == held, "R3 hold", {dataOut, bpvOut}, held);
      end
      step(1'b1, symArr[k][1], symArr[k][0]);
      if (k < DEPTH) begin
        check({dataOut, bpvOut} == 2'b00, "R2 warmup", {dataOut, bpvOut}, 2'b00);
      end else begin
        check({dataOut, bpvOut} == {expD[k-DEPTH], expV[k-DEPTH]}, tag,
              {dataOut, bpvOut}, {expD[k-DEPTH], expV[k-DEPTH]});
      end
      check(!(bpvOut && !dataOut), "R9", {dataOut, bpvOut}, {1'b1, bpvOut});
      held = {dataOut, bpvOut};
    end
    step(1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // R5 R6: random rails, plain decoding for every length select
    for (int ls = 0; ls < 8; ls++) begin
      genRandSym();
      amiModel();
      runStream("R5 R6 plain", 1'b0, 3'(ls));
    end
    // R4: substitution disabled leaves codewords as flagged marks
    genData(); encHdb(); amiModel();
    runStream("R4 disabled hdb", 1'b0, 3'd0);
    genData(); encB8(); amiModel();
    runStream("R4 disabled b8", 1'b0, 3'd3);
    // R4: length select 001 falls back to plain decoding
    genData(); encB8(); amiModel();
    runStream("R4 len001", 1'b1, 3'd1);
    // R8: four-zero substitution
    for (int r = 0; r < 2; r++) begin
      genData(); encHdb(); dataModel();
      runStream("R8 hdb", 1'b1, 3'd0);
    end
    // R7: eight-zero substitution on every selecting length
    for (int ls = 2; ls < 8; ls++) begin
      genData(); encB8(); dataModel();
      runStream("R7 b8", 1'b1, 3'(ls));
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule